// File: doc/BRIEF.md
# CAN Controller Interrupt Source Aggregator

This block sits between a CAN controller's protocol engine, its bank of message buffers and the interrupt controller of the chip. Every event reaches it as a one-cycle strobe: a buffer finished receiving, a buffer finished sending, a remote frame arrived in a send buffer, the engine saw a bus error of some kind, the node's fault-confinement state moved while it was sending or receiving, or a received frame overran. The block turns these strobes into sticky status flags that software clears by writing ones, and it combines the flags under their enables into one registered interrupt request.

There is one flag for each message buffer, gated onto the request line by that buffer's own enable bit. There are seven controller flags: five bus error kinds, one for bus state changes and one for overrun. Each is gated by one bit of a controller enable vector. Flags latch whether or not they are enabled, so software can poll them. A remote frame only raises a buffer flag when the buffer is not set to answer remote frames on its own. The last bus error code is kept for diagnosis.

Top module: `can_irq_aggregator`

## Requirements
- R1: While reset is high and on the first cycle after it, every buffer flag, every controller flag, the last error code and the interrupt request are 0.
- R2: A receive-done or transmit-done strobe on buffer i sets buffer flag i on the next clock edge and leaves the other buffer flags unchanged.
- R3: A remote-frame strobe on buffer i sets buffer flag i only when that buffer's auto-answer bit is 0. When the bit is 1 the flag stays as it was.
- R4: A bus error strobe sets a controller flag chosen by the error code: code 1 (bit) sets bit 0, 2 (stuff) sets bit 1, 3 (form) sets bit 2, 4 (CRC) sets bit 3, 5 (acknowledge) sets bit 4. Codes 0, 6 and 7 set no flag.
- R5: A state-change strobe sets controller flag bit 5 when the node enters error-passive while sending or while receiving, or enters bus-off while sending. Entering bus-off while receiving sets nothing.
- R6: An overrun strobe sets controller flag bit 6.
- R7: Writing 1 to a flag's clear bit clears that flag on the next edge. If a setting event for the same flag arrives in the same cycle, the flag stays 1.
- R8: Every bus error strobe loads its 3-bit code into the last-error output on the next edge. This includes codes 0, 6 and 7.
- R9: The interrupt request is 1 one edge after any cycle in which some buffer flag and its enable, or some controller flag and its enable bit, are both 1. It is 0 one edge after a cycle in which no such pair exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_done | input | NUM_BUF | Per-buffer receive-complete strobe |
| tx_done | input | NUM_BUF | Per-buffer transmit-complete strobe |
| rmt_rcvd | input | NUM_BUF | Per-buffer remote-frame-received strobe |
| buf_ie | input | NUM_BUF | Per-buffer interrupt enable |
| buf_autoans | input | NUM_BUF | Per-buffer remote auto-answer mode |
| berr_stb | input | 1 | Bus error strobe |
| berr_code | input | 3 | Bus error kind (1 bit, 2 stuff, 3 form, 4 CRC, 5 ack) |
| fc_stb | input | 1 | Fault-confinement state-change strobe |
| fc_busoff | input | 1 | 1 = entered bus-off, 0 = entered error-passive |
| fc_is_tx | input | 1 | 1 = node was sending, 0 = receiving |
| ovr_stb | input | 1 | Receive overrun strobe |
| ctl_ie | input | 7 | Controller flag enables, same bit order as ctl_flag |
| msg_clr | input | NUM_BUF | Write-one-to-clear for buffer flags |
| ctl_clr | input | 7 | Write-one-to-clear for controller flags |
| msg_flag | output | NUM_BUF | Sticky per-buffer flags |
| ctl_flag | output | 7 | Sticky controller flags (0-4 bus errors, 5 state change, 6 overrun) |
| last_err | output | 3 | Code of the most recent bus error |
| irq | output | 1 | Registered combined interrupt request |

## Verification
The buffer flags are driven with receive and transmit strobes on the lowest, a middle and the highest buffer index, which shows that each buffer is decoded separately. Remote frames are sent once with auto-answer set and once clear, which separates the two modes. All eight error codes and all four combinations of direction and fault state are applied, so the bench can tell a decoder that swaps or drops a case. Simultaneous clear and set, masked and unmasked flags, and a clear that lands while the request is still registered expose mistakes in priority and latency.

// File: rtl/can_irq_pkg.sv
package can_irq_pkg;

    localparam int NUM_BUF   = 32;
    localparam int CODE_W    = 3;
    localparam int NUM_BERR  = 5;
    localparam int CTL_W     = NUM_BERR + 2;

    // controller flag positions
    localparam int CI_STCHG  = NUM_BERR;
    localparam int CI_OVR    = NUM_BERR + 1;

    // bus error codes
    localparam logic [CODE_W-1:0] BERR_BIT   = 3'd1;
    localparam logic [CODE_W-1:0] BERR_STUFF = 3'd2;
    localparam logic [CODE_W-1:0] BERR_FORM  = 3'd3;
    localparam logic [CODE_W-1:0] BERR_CRC   = 3'd4;
    localparam logic [CODE_W-1:0] BERR_ACK   = 3'd5;

    typedef struct packed {
        logic                ovr;
        logic                stchg;
        logic [NUM_BERR-1:0] berr;
    } ctl_ev_t;

    function automatic logic sticky_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

    function automatic logic [NUM_BERR-1:0] berr_decode(input logic [CODE_W-1:0] code);
        logic [NUM_BERR-1:0] v;
        v = '0;
        case (code)
            BERR_BIT:   v[0] = 1'b1;
            BERR_STUFF: v[1] = 1'b1;
            BERR_FORM:  v[2] = 1'b1;
            BERR_CRC:   v[3] = 1'b1;
            BERR_ACK:   v[4] = 1'b1;
            default:    v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/can_msg_flags.sv
module can_msg_flags
    import can_irq_pkg::*;
#(
    parameter int NB = NUM_BUF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NB-1:0] rx_done,
    input  logic [NB-1:0] tx_done,
    input  logic [NB-1:0] rmt_rcvd,
    input  logic [NB-1:0] buf_autoans,
    input  logic [NB-1:0] msg_clr,
    output logic [NB-1:0] msg_flag
);

    for (genvar i = 0; i < NB; i++) begin : g_buf
        logic set_i;
        assign set_i = rx_done[i] | tx_done[i] | (rmt_rcvd[i] & ~buf_autoans[i]);

        always_ff @(posedge clk) begin
            if (rst) msg_flag[i] <= 1'b0;
            else     msg_flag[i] <= sticky_next(msg_flag[i], set_i, msg_clr[i]);
        end

        // R2
        p_done_sets_r2: assert property (@(posedge clk) disable iff (rst)
            (rx_done[i] || tx_done[i]) |=> msg_flag[i]);
        // R3
        p_autoans_quiet_r3: assert property (@(posedge clk) disable iff (rst)
            (rmt_rcvd[i] && buf_autoans[i] && !rx_done[i] && !tx_done[i] && !msg_flag[i])
            |=> !msg_flag[i]);
        // R7
        p_clear_r7: assert property (@(posedge clk) disable iff (rst)
            (msg_clr[i] && !rx_done[i] && !tx_done[i] && !rmt_rcvd[i]) |=> !msg_flag[i]);
    end

endmodule

// File: rtl/can_ctl_events.sv
module can_ctl_events
    import can_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              berr_stb,
    input  logic [CODE_W-1:0] berr_code,
    input  logic              fc_stb,
    input  logic              fc_busoff,
    input  logic              fc_is_tx,
    input  logic              ovr_stb,
    input  logic [CTL_W-1:0]  ctl_clr,
    output logic [CTL_W-1:0]  ctl_flag,
    output logic [CODE_W-1:0] last_err
);

    ctl_ev_t ev;
    logic [CTL_W-1:0] ev_bits;

    always_comb begin
        ev       = '0;
        ev.berr  = berr_stb ? berr_decode(berr_code) : '0;
        ev.stchg = fc_stb & (fc_is_tx | ~fc_busoff);
        ev.ovr   = ovr_stb;
    end
    assign ev_bits = ev;

    for (genvar k = 0; k < CTL_W; k++) begin : g_ctl
        always_ff @(posedge clk) begin
            if (rst) ctl_flag[k] <= 1'b0;
            else     ctl_flag[k] <= sticky_next(ctl_flag[k], ev_bits[k], ctl_clr[k]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           last_err <= '0;
        else if (berr_stb) last_err <= berr_code;
    end

    // R8
    p_code_capture_r8: assert property (@(posedge clk) disable iff (rst)
        berr_stb |=> last_err == $past(berr_code));
    // R5
    p_busoff_rx_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (fc_stb && fc_busoff && !fc_is_tx && !ctl_flag[CI_STCHG]) |=> !ctl_flag[CI_STCHG]);
    // R6
    p_ovr_sets_r6: assert property (@(posedge clk) disable iff (rst)
        ovr_stb |=> ctl_flag[CI_OVR]);
    // R4
    p_bad_code_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (berr_stb && (berr_code == 3'd0 || berr_code > BERR_ACK) && ctl_flag[NUM_BERR-1:0] == '0)
        |=> ctl_flag[NUM_BERR-1:0] == '0);

endmodule

// File: rtl/can_irq_combine.sv
module can_irq_combine
    import can_irq_pkg::*;
#(
    parameter int NB = NUM_BUF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NB-1:0]    msg_flag,
    input  logic [NB-1:0]    buf_ie,
    input  logic [CTL_W-1:0] ctl_flag,
    input  logic [CTL_W-1:0] ctl_ie,
    output logic             irq
);

    logic pend;
    assign pend = (|(msg_flag & buf_ie)) | (|(ctl_flag & ctl_ie));

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= pend;
    end

endmodule

// File: rtl/can_irq_aggregator.sv
module can_irq_aggregator
    import can_irq_pkg::*;
#(
    parameter int NB = NUM_BUF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NB-1:0]     rx_done,
    input  logic [NB-1:0]     tx_done,
    input  logic [NB-1:0]     rmt_rcvd,
    input  logic [NB-1:0]     buf_ie,
    input  logic [NB-1:0]     buf_autoans,
    input  logic              berr_stb,
    input  logic [CODE_W-1:0] berr_code,
    input  logic              fc_stb,
    input  logic              fc_busoff,
    input  logic              fc_is_tx,
    input  logic              ovr_stb,
    input  logic [CTL_W-1:0]  ctl_ie,
    input  logic [NB-1:0]     msg_clr,
    input  logic [CTL_W-1:0]  ctl_clr,
    output logic [NB-1:0]     msg_flag,
    output logic [CTL_W-1:0]  ctl_flag,
    output logic [CODE_W-1:0] last_err,
    output logic              irq
);

    can_msg_flags #(.NB(NB)) u_msg (
        .clk(clk), .rst(rst),
        .rx_done(rx_done), .tx_done(tx_done), .rmt_rcvd(rmt_rcvd),
        .buf_autoans(buf_autoans), .msg_clr(msg_clr), .msg_flag(msg_flag)
    );

    can_ctl_events u_ctl (
        .clk(clk), .rst(rst),
        .berr_stb(berr_stb), .berr_code(berr_code),
        .fc_stb(fc_stb), .fc_busoff(fc_busoff), .fc_is_tx(fc_is_tx),
        .ovr_stb(ovr_stb), .ctl_clr(ctl_clr),
        .ctl_flag(ctl_flag), .last_err(last_err)
    );

    can_irq_combine #(.NB(NB)) u_irq (
        .clk(clk), .rst(rst),
        .msg_flag(msg_flag), .buf_ie(buf_ie),
        .ctl_flag(ctl_flag), .ctl_ie(ctl_ie),
        .irq(irq)
    );

    // R9
    p_irq_follows_r9: assert property (@(posedge clk) disable iff (rst)
        ((|(msg_flag & buf_ie)) || (|(ctl_flag & ctl_ie))) |=> irq);
    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (!(|(msg_flag & buf_ie)) && !(|(ctl_flag & ctl_ie))) |=> !irq);
    // R1
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (msg_flag == '0 && ctl_flag == '0 && last_err == '0 && !irq));

endmodule

// File: tb/can_irq_aggregator_tb.sv
module can_irq_aggregator_tb;
    import can_irq_pkg::*;

    localparam int  NB     = NUM_BUF;
    localparam time CLK_HP = 5ns;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NB-1:0] rx_done = '0, tx_done = '0, rmt_rcvd = '0, buf_ie = '0, buf_autoans = '0, msg_clr = '0;
    logic berr_stb = 1'b0, fc_stb = 1'b0, fc_busoff = 1'b0, fc_is_tx = 1'b0, ovr_stb = 1'b0;
    logic [CODE_W-1:0] berr_code = '0;
    logic [CTL_W-1:0]  ctl_ie = '0, ctl_clr = '0;
    logic [NB-1:0]     msg_flag;
    logic [CTL_W-1:0]  ctl_flag;
    logic [CODE_W-1:0] last_err;
    logic              irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_HP) clk = ~clk;

    can_irq_aggregator #(.NB(NB)) u_dut (
        .clk(clk), .rst(rst),
        .rx_done(rx_done), .tx_done(tx_done), .rmt_rcvd(rmt_rcvd),
        .buf_ie(buf_ie), .buf_autoans(buf_autoans),
        .berr_stb(berr_stb), .berr_code(berr_code),
        .fc_stb(fc_stb), .fc_busoff(fc_busoff), .fc_is_tx(fc_is_tx),
        .ovr_stb(ovr_stb), .ctl_ie(ctl_ie),
        .msg_clr(msg_clr), .ctl_clr(ctl_clr),
        .msg_flag(msg_flag), .ctl_flag(ctl_flag), .last_err(last_err), .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_all();
        msg_clr = '1; ctl_clr = '1;
        cyc();
        msg_clr = '0; ctl_clr = '0;
        cyc();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (2) cyc();
        chk("R1 msg_flag", msg_flag, 0);
        chk("R1 ctl_flag", ctl_flag, 0);
        chk("R1 last_err", last_err, 0);
        chk("R1 irq", irq, 0);
        rst = 1'b0;
        cyc();
        chk("R1 after release", {msg_flag, ctl_flag, last_err, irq}, 0);
    endtask

    task automatic t_msg();
        rx_done[3] = 1'b1;
        cyc();
        rx_done = '0;
        chk("R2 rx buf3", msg_flag, 64'h8);
        tx_done[31] = 1'b1;
        cyc();
        tx_done = '0;
        chk("R2 tx buf31", msg_flag, 64'h8000_0008);
        rx_done[0] = 1'b1;
        cyc();
        rx_done = '0;
        chk("R2 rx buf0", msg_flag, 64'h8000_0009);
        clear_all();
        chk("R7 clear all", msg_flag, 0);
    endtask

    task automatic t_remote();
        buf_autoans[5] = 1'b1;
        rmt_rcvd[5] = 1'b1;
        cyc();
        rmt_rcvd = '0;
        chk("R3 autoans set", msg_flag, 0);
        buf_autoans[6] = 1'b0;
        rmt_rcvd[6] = 1'b1;
        cyc();
        rmt_rcvd = '0;
        chk("R3 autoans clear", msg_flag, 64'h40);
        buf_autoans = '0;
        clear_all();
    endtask

    task automatic t_berr();
        for (int c = 0; c < 8; c++) begin
            logic [63:0] exp;
            exp = (c >= 1 && c <= 5) ? (64'd1 << (c - 1)) : 64'd0;
            berr_stb = 1'b1;
            berr_code = 3'(c);
            cyc();
            berr_stb = 1'b0;
            chk($sformatf("R8 code %0d", c), last_err, 64'(c));
            chk($sformatf("R4 code %0d", c), ctl_flag, exp);
            clear_all();
        end
    endtask

    task automatic t_fc();
        for (int m = 0; m < 4; m++) begin
            logic bo, tx;
            bo = m[1]; tx = m[0];
            fc_stb = 1'b1; fc_busoff = bo; fc_is_tx = tx;
            cyc();
            fc_stb = 1'b0;
            chk($sformatf("R5 busoff=%0d tx=%0d", bo, tx), ctl_flag,
                (bo && !tx) ? 64'd0 : 64'h20);
            clear_all();
        end
    endtask

    task automatic t_ovr();
        ovr_stb = 1'b1;
        cyc();
        ovr_stb = 1'b0;
        chk("R6 overrun", ctl_flag, 64'h40);
        clear_all();
    endtask

    task automatic t_clear_race();
        rx_done[4] = 1'b1;
        cyc();
        rx_done[4] = 1'b0;
        tx_done[4] = 1'b1;
        msg_clr[4] = 1'b1;
        cyc();
        tx_done[4] = 1'b0;
        chk("R7 event wins", msg_flag, 64'h10);
        cyc();
        msg_clr[4] = 1'b0;
        chk("R7 clear alone", msg_flag, 0);
        ovr_stb = 1'b1;
        cyc();
        ovr_stb = 1'b0;
        ctl_clr[6] = 1'b1;
        ovr_stb = 1'b1;
        cyc();
        ctl_clr = '0;
        ovr_stb = 1'b0;
        chk("R7 ctl event wins", ctl_flag, 64'h40);
        clear_all();
    endtask

    task automatic t_irq();
        rx_done[2] = 1'b1;
        cyc();
        rx_done = '0;
        chk("R9 no irq same edge", irq, 0);
        cyc();
        chk("R9 masked", irq, 0);
        buf_ie[2] = 1'b1;
        cyc();
        chk("R9 enabled", irq, 1);
        msg_clr[2] = 1'b1;
        cyc();
        msg_clr = '0;
        chk("R9 latency after clear", irq, 1);
        cyc();
        chk("R9 drops", irq, 0);
        ctl_ie[CI_OVR] = 1'b1;
        ovr_stb = 1'b1;
        cyc();
        ovr_stb = 1'b0;
        chk("R9 ctl one edge", irq, 0);
        cyc();
        chk("R9 ctl raised", irq, 1);
        ctl_ie = '0;
        buf_ie = '0;
        clear_all();
        chk("R9 idle", irq, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        t_reset();
        t_msg();
        t_remote();
        t_berr();
        t_fc();
        t_ovr();
        t_clear_race();
        t_irq();
        report();
    end

endmodule